// File: doc/BRIEF.md
# Serial Echo Output with Selectable Shift-Out Edge

This block produces the serial-data output of a 16-bit shift-in port. While a new word is being clocked in, the pin plays back the word held in the shift register from the previous frame, most significant bit first. The pin can feed the data input of the next device in a daisy chain, or the host can read it to confirm what it wrote.

The serial clock, the active-low select and the data input arrive asynchronously. Each passes through a two-flop synchronizer into a faster system clock, and the serial clock edges are detected there. A command word can choose whether the output pin moves on the falling edge of the serial clock or on the rising edge. With the falling edge, the output stream trails the input stream by 16.5 serial clock periods. With the rising edge, it trails by exactly 16. A reset always brings the block back to the falling-edge choice.

Top module: `echo_dout_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, `dout_o` is 0, `edge_mode_o` is 0 (falling-edge mode) and the shift register holds all zeros. The first frame after reset therefore plays back zeros.
- R2: Each rising serial clock edge seen while `cs_n_pin` is low shifts `din_pin` into the 16-bit register at the LSB end, so words enter MSB first. The output plays back the register contents in order, starting with the MSB of the previous word.
- R3: In rising-edge mode (`edge_mode_o` = 1), `dout_o` takes the bit leaving the register at each rising serial clock edge and does not change on falling edges. An input bit reappears exactly 16 serial clock periods later.
- R4: In falling-edge mode (`edge_mode_o` = 0), `dout_o` takes the bit that left the register at the preceding rising edge. It changes only on falling edges, so an input bit reappears 16.5 serial clock periods later.
- R5: When `cs_n_pin` rises after at least 16 bits, bits [15:12] of the last 16 bits received select the mode. 4'b1110 selects rising-edge mode and 4'b1010 selects falling-edge mode. The low 12 bits are ignored, and any other value leaves the mode unchanged.
- R6: A mode change takes effect at the end of the frame that carried it. During that frame the output keeps the old edge.
- R7: While `cs_n_pin` is high, serial clock edges and `din_pin` are ignored. `dout_o` holds its value and the register does not shift.
- R8: A frame of fewer than 16 bits never changes the mode. In a frame longer than 16 bits, the last 16 bits form the command word.
- R9: `dout_o` changes on the third rising edge of `clk` after the serial clock pin toggles. This counts two synchronizer flops and one output flop, and the serial clock must stay in each phase for at least 4 `clk` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous active-low clear |
| sclk_pin | input | 1 | Serial clock, asynchronous to `clk` |
| cs_n_pin | input | 1 | Active-low frame select, asynchronous |
| din_pin | input | 1 | Serial data in, sampled on rising serial clock |
| dout_o | output | 1 | Serial echo output |
| edge_mode_o | output | 1 | Current output edge: 0 falling, 1 rising |

## Verification
The hardest case to reach from the ports is the frame that carries a mode command. The old edge must persist for the whole frame, and the new edge must appear only in the next frame. The stimulus sends a rising-edge command, then a frame in that mode, then a falling-edge command, comparing the output at every half period against a model that switches edge only when select rises. Frames of 8 and 20 bits, and serial clock toggling with select high, exercise the count and hold rules. The third-cycle latency is probed twice around every edge.

// File: rtl/echo_pkg.sv
package echo_pkg;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } out_edge_e;

  localparam logic [3:0] OP_SEL_RISE = 4'b1110;
  localparam logic [3:0] OP_SEL_FALL = 4'b1010;

  // Mode after a completed frame whose command nibble is op.
  function automatic out_edge_e next_edge(input out_edge_e cur,
                                          input logic [3:0] op);
    out_edge_e nxt;
    nxt = cur;
    if (op == OP_SEL_RISE) nxt = EDGE_RISE;
    else if (op == OP_SEL_FALL) nxt = EDGE_FALL;
    return nxt;
  endfunction

  // Value the output flop should take for a given edge event.
  function automatic logic pick_out(input out_edge_e mode, input logic rise_ev,
                                    input logic fall_ev, input logic leaving,
                                    input logic staged, input logic cur);
    logic v;
    v = cur;
    if (mode == EDGE_RISE && rise_ev) v = leaving;
    else if (mode == EDGE_FALL && fall_ev) v = staged;
    return v;
  endfunction

endpackage

// File: rtl/echo_sync.sv
module echo_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[0] <= RST_VAL;
          else        stage[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[s] <= RST_VAL;
          else        stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/echo_edges.sv
module echo_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic cs_n_s,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_rise,
  output logic frame_idle
);
  logic sclk_q;
  logic cs_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_n_q <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      cs_n_q <= cs_n_s;
    end
  end

  assign sclk_rise  = sclk_s & ~sclk_q & ~cs_n_s;
  assign sclk_fall  = ~sclk_s & sclk_q & ~cs_n_s;
  assign cs_rise    = cs_n_s & ~cs_n_q;
  assign frame_idle = cs_n_s;
endmodule

// File: rtl/echo_shifter.sv
module echo_shifter #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_idle,
  input  logic              shift_en,
  input  logic              din_s,
  output logic              msb,
  output logic [WORD_W-1:0] word,
  output logic              frame_full
);
  logic [CNT_W-1:0] bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
    end else if (shift_en) begin
      word <= {word[WORD_W-2:0], din_s};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
    end else if (frame_idle) begin
      bit_cnt <= '0;
    end else if (shift_en && bit_cnt != CNT_W'(WORD_W)) begin
      bit_cnt <= bit_cnt + CNT_W'(1);
    end
  end

  assign msb        = word[WORD_W-1];
  assign frame_full = (bit_cnt == CNT_W'(WORD_W));
endmodule

// File: rtl/echo_mode.sv
module echo_mode
  import echo_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_rise,
  input  logic            frame_full,
  input  logic [OP_W-1:0] op,
  output out_edge_e       mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= EDGE_FALL;
    end else if (cs_rise && frame_full) begin
      mode <= next_edge(mode, op);
    end
  end
endmodule

// File: rtl/echo_drive.sv
module echo_drive
  import echo_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  out_edge_e mode,
  input  logic      sclk_rise,
  input  logic      sclk_fall,
  input  logic      leaving,
  output logic      dout
);
  logic staged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged <= 1'b0;
      dout   <= 1'b0;
    end else begin
      if (sclk_rise) staged <= leaving;
      dout <= pick_out(mode, sclk_rise, sclk_fall, leaving, staged, dout);
    end
  end
endmodule

// File: rtl/echo_dout_top.sv
module echo_dout_top
  import echo_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int OP_W        = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_pin,
  input  logic cs_n_pin,
  input  logic din_pin,
  output logic dout_o,
  output logic edge_mode_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [2:0]        pins_s;
  logic              sclk_rise, sclk_fall, cs_rise, frame_idle;
  logic              msb, frame_full;
  logic [WORD_W-1:0] word;
  logic [OP_W-1:0]   op_nib;
  out_edge_e         mode;

  // {din, cs_n, sclk}; cs_n resets high so no phantom frame end appears
  echo_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({din_pin, cs_n_pin, sclk_pin}), .q(pins_s)
  );

  echo_edges u_edges (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(pins_s[0]), .cs_n_s(pins_s[1]),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_rise(cs_rise), .frame_idle(frame_idle)
  );

  echo_shifter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .frame_idle(frame_idle), .shift_en(sclk_rise), .din_s(pins_s[2]),
    .msb(msb), .word(word), .frame_full(frame_full)
  );

  assign op_nib = word[WORD_W-1 -: OP_W];

  echo_mode #(.OP_W(OP_W)) u_mode (
    .clk(clk), .rst_n(rst_n),
    .cs_rise(cs_rise), .frame_full(frame_full), .op(op_nib), .mode(mode)
  );

  echo_drive u_drive (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .leaving(msb), .dout(dout_o)
  );

  assign edge_mode_o = mode;
endmodule

// File: rtl/echo_dout_checker.sv
module echo_dout_checker #(
  parameter int OP_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dout,
  input logic            mode,
  input logic            sclk_rise,
  input logic            sclk_fall,
  input logic            cs_rise,
  input logic            frame_idle,
  input logic            frame_full,
  input logic            msb,
  input logic [OP_W-1:0] op
);
  AST_HOLD_WHILE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    frame_idle |=> $stable(dout)); // R7

  AST_RISE_MODE_TAKES_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && sclk_rise) |=> (dout == $past(msb))); // R3

  AST_RISE_MODE_FALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && sclk_fall) |=> $stable(dout)); // R3

  AST_FALL_MODE_RISE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && sclk_rise) |=> $stable(dout)); // R4

  AST_MODE_ONLY_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(mode)); // R6

  AST_SHORT_FRAME_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !frame_full) |=> $stable(mode)); // R8

  AST_OP_SELECTS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && frame_full && op == 4'b1110) |=> mode); // R5

  AST_OP_SELECTS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && frame_full && op == 4'b1010) |=> !mode); // R5
endmodule

bind echo_dout_top echo_dout_checker #(.OP_W(OP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dout(dout_o), .mode(edge_mode_o),
  .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_rise(cs_rise),
  .frame_idle(frame_idle), .frame_full(frame_full), .msb(msb), .op(op_nib)
);

// File: tb/echo_dout_top_tb_top.sv
module echo_dout_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HP         = 6;   // clk cycles per serial clock phase
  localparam int LIMIT      = 150000;

  logic clk = 1'b0;
  logic rst_n, sclk_pin, cs_n_pin, din_pin;
  logic dout_o, edge_mode_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // behavioural model
  bit   hist[$];
  logic exp_dout, pend, exp_mode;
  int   fcnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  echo_dout_top dut_i (
    .clk(clk), .rst_n(rst_n), .sclk_pin(sclk_pin), .cs_n_pin(cs_n_pin),
    .din_pin(din_pin), .dout_o(dout_o), .edge_mode_o(edge_mode_o)
  );

  task automatic check(input string tag, input logic act, input logic exp,
                       input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    hist.delete();
    for (int i = 0; i < 16; i++) hist.push_back(1'b0);
    exp_dout = 1'b0;
    pend     = 1'b0;
    exp_mode = 1'b0;
  endtask

  // Called at a negedge of clk: toggles the serial clock and checks the output.
  task automatic sclk_edge(input logic lvl, input string tag);
    logic old;
    bit   o;
    old = exp_dout;
    sclk_pin = lvl;
    if (!cs_n_pin) begin
      if (lvl) begin
        o = hist.pop_front();
        hist.push_back(din_pin);
        fcnt++;
        pend = o;
        if (exp_mode) exp_dout = o;
      end else if (!exp_mode) begin
        exp_dout = pend;
      end
    end
    repeat (2) @(negedge clk);
    check("R9", dout_o, old, "dout two cycles after edge");
    @(negedge clk);
    check("R9", dout_o, exp_dout, "dout three cycles after edge");
    repeat (HP-3) @(negedge clk);
    check(tag, dout_o, exp_dout, "dout at end of phase");
  endtask

  task automatic send_frame(input logic [31:0] w, input int n,
                            input string tag, input string mtag);
    logic [3:0] op;
    @(negedge clk);
    cs_n_pin = 1'b0;
    fcnt     = 0;
    din_pin  = w[n-1];
    repeat (HP) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      din_pin = w[n-1-i];
      sclk_edge(1'b1, tag);
      sclk_edge(1'b0, tag);
    end
    cs_n_pin = 1'b1;
    if (fcnt >= 16) begin
      op = {hist[0], hist[1], hist[2], hist[3]};
      if (op == 4'b1110) exp_mode = 1'b1;
      else if (op == 4'b1010) exp_mode = 1'b0;
    end
    repeat (HP) @(negedge clk);
    check(mtag, edge_mode_o, exp_mode, "mode after frame");
    check(tag, dout_o, exp_dout, "dout after frame");
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sclk_pin = 1'b0; cs_n_pin = 1'b1; din_pin = 1'b0;
    model_clear();
    repeat (5) @(negedge clk);
    check("R1", dout_o, 1'b0, "dout in reset");
    check("R1", edge_mode_o, 1'b0, "mode in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", dout_o, 1'b0, "dout after reset");

    send_frame(32'h3C5A, 16, "R2", "R4");   // plays back zeros
    send_frame(32'hE123, 16, "R6", "R5");   // rise command, old edge in frame
    check("R5", edge_mode_o, 1'b1, "rise selected");
    send_frame(32'h9F06, 16, "R3", "R3");   // rising-edge mode frame

    // R7: serial clock activity while deselected
    @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      din_pin = k[0];
      sclk_edge(1'b1, "R7");
      sclk_edge(1'b0, "R7");
    end
    send_frame(32'hA777, 16, "R6", "R5");   // fall command, rise edge still in use
    check("R5", edge_mode_o, 1'b0, "fall selected");
    send_frame(32'h00C5, 16, "R4", "R4");   // falling-edge mode frame
    send_frame(32'h00E5, 8,  "R4", "R8");   // short frame, op bits present
    check("R8", edge_mode_o, 1'b0, "short frame kept mode");
    send_frame(32'h5E0F1, 20, "R4", "R8");  // long frame, last 16 bits = E0F1
    check("R8", edge_mode_o, 1'b1, "long frame tail selected rise");
    send_frame(32'h6ABC, 16, "R3", "R5");   // unrelated op keeps mode
    check("R5", edge_mode_o, 1'b1, "other op ignored");
    send_frame(32'hB00F, 16, "R3", "R3");

    // R1: clear in the middle of operation
    @(negedge clk);
    rst_n = 1'b0;
    model_clear();
    repeat (2) @(negedge clk);
    check("R1", dout_o, 1'b0, "dout after clear");
    check("R1", edge_mode_o, 1'b0, "mode after clear");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    send_frame(32'h1234, 16, "R1", "R1");    // plays back zeros

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule